// File: doc/BRIEF.md
# Dual-Port RAM with Multiplexed Address/Data Ports

A true dual-port word memory with two fully independent access ports, left and right, both clocked by one clock. Each port has its own active-low chip select, write enable, output enable and two active-low byte-half enables. A mode input chooses where the port takes its address from. In mode 0 it uses a dedicated address bus. In mode 1 it uses an address captured from the low bits of that port's data input, on a cycle where the address-valid strobe is high.

Tri-state pins are modelled as a registered data-out bus plus a per-byte drive-enable vector. Both ports can reach any word in the same cycle. Byte lanes are qualified on every read and every write. When both ports write one byte of the same word in the same cycle, the left port's byte is stored.

Top module: `dpr_mux_ram`

## Requirements
- R1: A port with mode 0 addresses the array from its address bus. A port with mode 1 addresses the array from its latched address, and the address bus is ignored.
- R2: In mode 1, a clock edge with the strobe high loads data-input bits ADDR_W-1..0 into the port's latched address and performs no access, so the drive-enable is 0 next cycle. The latched address holds until the next such edge. In mode 0 the strobe has no effect on either the latch or the access.
- R3: With chip select high the port neither drives nor writes, whatever its other controls are.
- R4: With chip select low, write enable high and output enable high, nothing is driven.
- R5: With both byte enables high, no lane is driven and no byte is written.
- R6: A read needs chip select low, write enable high and output enable low. One cycle later, drive-enable bit 0 (the lower byte, data bits 7..0) equals the inverse of the lower enable, and bit 1 (the upper byte, bits 15..8) equals the inverse of the upper enable. Driven lanes carry the stored byte and undriven lanes read as zero.
- R7: A write needs chip select low and write enable low; output enable is ignored. Only the lanes whose enable is low are updated, and a write drives nothing.
- R8: Both ports may access any words in the same cycle, including both reading the same word. A read returns the contents as they were before any write in the same cycle.
- R9: When both ports write the same byte of the same word in one cycle, the left port's byte is stored. Bytes that only one port writes are stored from that port.
- R10: During reset and right after it, both drive-enables and both data-outs are zero, and both latched addresses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_cs_n | input | 1 | Left chip select, active low |
| l_we_n | input | 1 | Left write enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_ub_n | input | 1 | Left upper byte enable, active low |
| l_lb_n | input | 1 | Left lower byte enable, active low |
| l_mode | input | 1 | Left mode: 0 separate address, 1 multiplexed |
| l_adv | input | 1 | Left address-valid strobe (mode 1 only) |
| l_addr | input | ADDR_W | Left address bus (mode 0) |
| l_din | input | DATA_W | Left write data / multiplexed address |
| l_dout | output | DATA_W | Left read data |
| l_drv | output | DATA_W/8 | Left per-byte drive-enable |
| r_cs_n | input | 1 | Right chip select, active low |
| r_we_n | input | 1 | Right write enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_ub_n | input | 1 | Right upper byte enable, active low |
| r_lb_n | input | 1 | Right lower byte enable, active low |
| r_mode | input | 1 | Right mode: 0 separate address, 1 multiplexed |
| r_adv | input | 1 | Right address-valid strobe (mode 1 only) |
| r_addr | input | ADDR_W | Right address bus (mode 0) |
| r_din | input | DATA_W | Right write data / multiplexed address |
| r_dout | output | DATA_W | Right read data |
| r_drv | output | DATA_W/8 | Right per-byte drive-enable |

## Verification
The bench builds the block with DATA_W=16 and ADDR_W=6, a 64-word array. This makes it cheap to write every word and read all of it back through both ports and in both modes. With a 6-bit latch inside a 16-bit data word, the upper ten data bits during a strobe must be dropped, and the bench sets them to a nonzero pattern to show that they are. The same small depth keeps collisions and read-during-write cases on a handful of known words.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

   localparam int LANE_W = 8;

   typedef enum logic {
      MODE_SRAM = 1'b0,
      MODE_MUX  = 1'b1
   } port_mode_e;

   function automatic int lane_count(input int width);
      return width / LANE_W;
   endfunction

endpackage

// File: rtl/dpr_port_ctrl.sv
module dpr_port_ctrl
   import dpr_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 10,
   localparam int NB    = lane_count(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic              ub_n,
   input  logic              lb_n,
   input  logic              mode,
   input  logic              adv,
   input  logic [ADDR_W-1:0] addr_bus,
   input  logic [ADDR_W-1:0] strobe_bus,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [NB-1:0]     wr_be,
   output logic [NB-1:0]     rd_be
);

   port_mode_e        mode_e;
   logic              addr_phase;
   logic              selected;
   logic [ADDR_W-1:0] lat_q;
   logic [NB-1:0]     lane_en;

   assign mode_e     = port_mode_e'(mode);
   assign addr_phase = (mode_e == MODE_MUX) && adv;
   assign selected   = !cs_n && !addr_phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          lat_q <= '0;
      else if (addr_phase) lat_q <= strobe_bus;
   end

   assign acc_addr = (mode_e == MODE_MUX) ? lat_q : addr_bus;

   for (genvar b = 0; b < NB; b++) begin : g_lane
      if (b < NB / 2) begin : g_low
         assign lane_en[b] = !lb_n;
      end else begin : g_high
         assign lane_en[b] = !ub_n;
      end
   end

   assign wr_be = (selected && !we_n)         ? lane_en : '0;
   assign rd_be = (selected && we_n && !oe_n) ? lane_en : '0;

   // R2: the latch may change only on a strobe edge in multiplexed mode
   a_r2_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(mode && adv) |=> (lat_q == $past(lat_q)));

endmodule

// File: rtl/dpr_core.sv
module dpr_core
   import dpr_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 10,
   localparam int NB    = lane_count(DATA_W),
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [1:0][ADDR_W-1:0]       addr,
   input  logic [1:0][NB-1:0]           wr_be,
   input  logic [1:0][NB-1:0]           rd_be,
   input  logic [1:0][DATA_W-1:0]       din,
   output logic [1:0][DATA_W-1:0]       dout,
   output logic [1:0][NB-1:0]           drv
);

   logic [NB-1:0][LANE_W-1:0] mem [DEPTH];
   logic                      same_word;

   assign same_word = (addr[0] == addr[1]);

   // port 0 is the left port and wins a same-byte collision
   always_ff @(posedge clk) begin
      for (int b = 0; b < NB; b++) begin
         if (wr_be[1][b] && !(wr_be[0][b] && same_word))
            mem[addr[1]][b] <= din[1][b*LANE_W +: LANE_W];
         if (wr_be[0][b])
            mem[addr[0]][b] <= din[0][b*LANE_W +: LANE_W];
      end
   end

   for (genvar p = 0; p < 2; p++) begin : g_rd
      logic [NB-1:0]     drv_q;
      logic [DATA_W-1:0] q_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            drv_q <= '0;
            q_q   <= '0;
         end else begin
            drv_q <= rd_be[p];
            for (int b = 0; b < NB; b++)
               q_q[b*LANE_W +: LANE_W] <= rd_be[p][b] ? mem[addr[p]][b] : '0;
         end
      end

      assign drv[p]  = drv_q;
      assign dout[p] = q_q;
   end

   for (genvar b = 0; b < NB; b++) begin : g_chk
      // R9: same byte written by both ports keeps the left byte
      a_r9_left_wins: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_be[0][b] && wr_be[1][b] && same_word)
         |=> (mem[$past(addr[0])][b] == $past(din[0][b*LANE_W +: LANE_W])));
   end

endmodule

// File: rtl/dpr_mux_ram.sv
module dpr_mux_ram
   import dpr_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 10,
   localparam int NB    = lane_count(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_cs_n,
   input  logic              l_we_n,
   input  logic              l_oe_n,
   input  logic              l_ub_n,
   input  logic              l_lb_n,
   input  logic              l_mode,
   input  logic              l_adv,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_din,
   output logic [DATA_W-1:0] l_dout,
   output logic [NB-1:0]     l_drv,
   input  logic              r_cs_n,
   input  logic              r_we_n,
   input  logic              r_oe_n,
   input  logic              r_ub_n,
   input  logic              r_lb_n,
   input  logic              r_mode,
   input  logic              r_adv,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_din,
   output logic [DATA_W-1:0] r_dout,
   output logic [NB-1:0]     r_drv
);

   if (DATA_W % (2 * LANE_W) != 0) begin : g_bad_width
      $error("dpr_mux_ram: DATA_W must split into two equal byte halves");
   end
   if (ADDR_W < 1 || ADDR_W > DATA_W) begin : g_bad_addr
      $error("dpr_mux_ram: ADDR_W must fit in the data bus");
   end

   logic [1:0]             cs_n_v, we_n_v, oe_n_v, ub_n_v, lb_n_v, mode_v, adv_v;
   logic [1:0][ADDR_W-1:0] addr_v, acc_addr;
   logic [1:0][DATA_W-1:0] din_v, dout_v;
   logic [1:0][NB-1:0]     wr_be, rd_be, drv_v;

   assign cs_n_v = {r_cs_n, l_cs_n};
   assign we_n_v = {r_we_n, l_we_n};
   assign oe_n_v = {r_oe_n, l_oe_n};
   assign ub_n_v = {r_ub_n, l_ub_n};
   assign lb_n_v = {r_lb_n, l_lb_n};
   assign mode_v = {r_mode, l_mode};
   assign adv_v  = {r_adv,  l_adv};
   assign addr_v = {r_addr, l_addr};
   assign din_v  = {r_din,  l_din};

   for (genvar p = 0; p < 2; p++) begin : g_port
      dpr_port_ctrl #(
         .DATA_W (DATA_W),
         .ADDR_W (ADDR_W)
      ) u_ctrl (
         .clk        (clk),
         .rst_n      (rst_n),
         .cs_n       (cs_n_v[p]),
         .we_n       (we_n_v[p]),
         .oe_n       (oe_n_v[p]),
         .ub_n       (ub_n_v[p]),
         .lb_n       (lb_n_v[p]),
         .mode       (mode_v[p]),
         .adv        (adv_v[p]),
         .addr_bus   (addr_v[p]),
         .strobe_bus (din_v[p][ADDR_W-1:0]),
         .acc_addr   (acc_addr[p]),
         .wr_be      (wr_be[p]),
         .rd_be      (rd_be[p])
      );

      // R3: deselected port drives nothing
      a_r3_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         cs_n_v[p] |=> (drv_v[p] == '0));
      // R4: output disable drives nothing
      a_r4_output_off: assert property (@(posedge clk) disable iff (!rst_n)
         (!cs_n_v[p] && we_n_v[p] && oe_n_v[p]) |=> (drv_v[p] == '0));
      // R5: no byte selected drives nothing
      a_r5_no_lanes: assert property (@(posedge clk) disable iff (!rst_n)
         (ub_n_v[p] && lb_n_v[p]) |=> (drv_v[p] == '0));
      // R2: a strobe cycle in multiplexed mode is address-only
      a_r2_strobe_only: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_v[p] && adv_v[p]) |=> (drv_v[p] == '0));
      // R6: lane enables follow the byte enables of the sampled read
      a_r6_lane_match: assert property (@(posedge clk) disable iff (!rst_n)
         (!cs_n_v[p] && we_n_v[p] && !oe_n_v[p] && !(mode_v[p] && adv_v[p]))
         |=> (drv_v[p][0] == !$past(lb_n_v[p]) && drv_v[p][NB-1] == !$past(ub_n_v[p])));
      // R7: a write cycle never drives
      a_r7_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
         (!cs_n_v[p] && !we_n_v[p]) |=> (drv_v[p] == '0));
   end

   dpr_core #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (acc_addr),
      .wr_be (wr_be),
      .rd_be (rd_be),
      .din   (din_v),
      .dout  (dout_v),
      .drv   (drv_v)
   );

   assign l_dout = dout_v[0];
   assign r_dout = dout_v[1];
   assign l_drv  = drv_v[0];
   assign r_drv  = drv_v[1];

endmodule

// File: tb/dpr_mux_ram_test.sv
`timescale 1ns/1ps
module dpr_mux_ram_test;
   localparam int DW = 16, AW = 6, NB = 2, WORDS = 64;

   logic clk = 1'b0;
   always #2 clk = ~clk;
   logic rst_n;

   logic l_cs_n, l_we_n, l_oe_n, l_ub_n, l_lb_n, l_mode, l_adv;
   logic r_cs_n, r_we_n, r_oe_n, r_ub_n, r_lb_n, r_mode, r_adv;
   logic [AW-1:0] l_addr, r_addr;
   logic [DW-1:0] l_din, r_din, l_dout, r_dout;
   logic [NB-1:0] l_drv, r_drv;

   dpr_mux_ram #(.DATA_W(DW), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n),
      .l_cs_n(l_cs_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_ub_n(l_ub_n), .l_lb_n(l_lb_n),
      .l_mode(l_mode), .l_adv(l_adv), .l_addr(l_addr), .l_din(l_din), .l_dout(l_dout), .l_drv(l_drv),
      .r_cs_n(r_cs_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_ub_n(r_ub_n), .r_lb_n(r_lb_n),
      .r_mode(r_mode), .r_adv(r_adv), .r_addr(r_addr), .r_din(r_din), .r_dout(r_dout), .r_drv(r_drv));

   typedef struct {
      logic cs_n, we_n, oe_n, ub_n, lb_n, mode, adv;
      logic [AW-1:0] addr;
      logic [DW-1:0] din;
   } pc_t;

   typedef struct {
      string tag;
      logic [NB-1:0] ld, rdv;
      logic [DW-1:0] lq, rq;
   } exp_t;

   exp_t sbq[$];
   exp_t mon_e;
   int n_chk = 0, n_err = 0;
   bit done = 1'b0;
   logic [DW-1:0] refm [WORDS];
   logic [AW-1:0] lat [2];

   function automatic pc_t mk(logic cs, logic we, logic oe, logic ub, logic lb,
                              logic md, logic av, logic [AW-1:0] a, logic [DW-1:0] d);
      pc_t c;
      c.cs_n = cs; c.we_n = we; c.oe_n = oe; c.ub_n = ub; c.lb_n = lb;
      c.mode = md; c.adv = av; c.addr = a; c.din = d;
      return c;
   endfunction

   function automatic pc_t idle();
      return mk(1, 1, 1, 1, 1, 0, 0, '0, '0);
   endfunction

   function automatic logic [DW-1:0] pat(int a);
      return 16'hC3A5 ^ DW'(a * 257 + a * 16);
   endfunction

   task automatic apply(pc_t l, pc_t r);
      l_cs_n = l.cs_n; l_we_n = l.we_n; l_oe_n = l.oe_n; l_ub_n = l.ub_n; l_lb_n = l.lb_n;
      l_mode = l.mode; l_adv = l.adv; l_addr = l.addr; l_din = l.din;
      r_cs_n = r.cs_n; r_we_n = r.we_n; r_oe_n = r.oe_n; r_ub_n = r.ub_n; r_lb_n = r.lb_n;
      r_mode = r.mode; r_adv = r.adv; r_addr = r.addr; r_din = r.din;
   endtask

   // driver: applies one cycle and pushes the reference result
   task automatic step(pc_t l, pc_t r, string tag);
      pc_t pp[2];
      logic [AW-1:0] a[2];
      logic [NB-1:0] wb[2], rb[2];
      logic [DW-1:0] q[2];
      logic ph[2];
      exp_t e;
      @(negedge clk);
      apply(l, r);
      pp[0] = l; pp[1] = r;
      for (int p = 0; p < 2; p++) begin
         logic [NB-1:0] be;
         ph[p] = pp[p].mode && pp[p].adv;
         a[p]  = pp[p].mode ? lat[p] : pp[p].addr;
         be    = {~pp[p].ub_n, ~pp[p].lb_n};
         wb[p] = (!pp[p].cs_n && !ph[p] && !pp[p].we_n) ? be : '0;
         rb[p] = (!pp[p].cs_n && !ph[p] && pp[p].we_n && !pp[p].oe_n) ? be : '0;
         q[p]  = '0;
         if (rb[p][0]) q[p][7:0]  = refm[a[p]][7:0];
         if (rb[p][1]) q[p][15:8] = refm[a[p]][15:8];
      end
      for (int p = 1; p >= 0; p--) begin
         if (wb[p][0]) refm[a[p]][7:0]  = pp[p].din[7:0];
         if (wb[p][1]) refm[a[p]][15:8] = pp[p].din[15:8];
      end
      for (int p = 0; p < 2; p++)
         if (ph[p]) lat[p] = pp[p].din[AW-1:0];
      e.tag = tag; e.ld = rb[0]; e.lq = q[0]; e.rdv = rb[1]; e.rq = q[1];
      sbq.push_back(e);
   endtask

   function automatic pc_t strb(logic [AW-1:0] a);
      return mk(0, 1, 0, 0, 0, 1, 1, a ^ 6'h15, {10'h2A5, a});
   endfunction

   // one access on port p; in mode 1 a strobe cycle goes first
   task automatic op(int p, bit m, pc_t c, string tag);
      pc_t s;
      if (m) begin
         s = strb(c.addr);
         step(p == 0 ? s : idle(), p == 0 ? idle() : s, tag);
         c.mode = 1'b1; c.adv = 1'b0; c.addr = ~c.addr;
      end else begin
         c.mode = 1'b0;
      end
      step(p == 0 ? c : idle(), p == 0 ? idle() : c, tag);
   endtask

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // monitor: compares each cycle's outputs with the queued reference
   always @(posedge clk) begin
      #1;
      if (sbq.size() != 0) begin
         mon_e = sbq.pop_front();
         chk(mon_e.tag, "left",  {14'b0, l_drv, l_dout}, {14'b0, mon_e.ld,  mon_e.lq});
         chk(mon_e.tag, "right", {14'b0, r_drv, r_dout}, {14'b0, mon_e.rdv, mon_e.rq});
      end
   end

   initial begin
      #(4ns * 200000);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      apply(idle(), idle());
      rst_n = 1'b0;
      lat[0] = '0; lat[1] = '0;
      repeat (3) @(negedge clk);
      chk("R10", "reset outputs", {l_drv, r_drv, l_dout}, '0);
      chk("R10", "reset right data", {16'b0, r_dout}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", "after release", {l_drv, r_drv, r_dout}, '0);

      // R7: fill every word from the left in mode 0
      for (int a = 0; a < WORDS; a++)
         step(mk(0, 0, 1, 0, 0, 0, 0, AW'(a), pat(a)), idle(), "R7 fill");

      // R10: right latch starts at zero
      step(idle(), mk(0, 1, 0, 0, 0, 1, 0, 6'h3F, '0), "R10 latch zero");

      // R1 and R8: right mode-1 sweep while left reads the same word in mode 0
      for (int a = 0; a < WORDS; a++) begin
         step(mk(0, 1, 0, 0, 0, 0, 0, AW'(a), '0), strb(AW'(a)), "R1 strobe");
         step(mk(0, 1, 0, 0, 0, 0, 0, AW'(a), '0),
              mk(0, 1, 0, 0, 0, 1, 0, ~AW'(a), '0), "R8 same word");
      end

      // control table on both ports in both modes
      for (int m = 0; m < 2; m++) begin
         for (int p = 0; p < 2; p++) begin
            logic [AW-1:0] t;
            t = AW'(8 + 2 * m + p);
            op(p, m[0], mk(1, 0, 0, 0, 0, 0, 0, t, 16'hDEAD), "R3 deselect write");
            op(p, m[0], mk(0, 1, 0, 0, 0, 0, 0, t, '0), "R3 readback");
            op(p, m[0], mk(1, 1, 0, 0, 0, 0, 0, t, '0), "R3 deselect read");
            op(p, m[0], mk(0, 1, 1, 0, 0, 0, 0, t, '0), "R4 output disable");
            op(p, m[0], mk(0, 1, 0, 1, 1, 0, 0, t, '0), "R5 no lane read");
            op(p, m[0], mk(0, 0, 0, 1, 1, 0, 0, t, 16'hBAD0), "R5 no lane write");
            op(p, m[0], mk(0, 1, 0, 0, 0, 0, 0, t, '0), "R5 readback");
            op(p, m[0], mk(0, 1, 0, 1, 0, 0, 0, t, '0), "R6 read low");
            op(p, m[0], mk(0, 1, 0, 0, 1, 0, 0, t, '0), "R6 read high");
            op(p, m[0], mk(0, 0, 1, 0, 0, 0, 0, t, 16'h1357), "R7 write both");
            op(p, m[0], mk(0, 0, 0, 1, 0, 0, 0, t, 16'hAA24), "R7 write low oe low");
            op(p, m[0], mk(0, 0, 1, 0, 1, 0, 0, t, 16'h68BB), "R7 write high");
            op(p, m[0], mk(0, 1, 0, 0, 0, 0, 0, t, '0), "R6 read both");
         end
      end

      // R2: strobe ignored in mode 0, latch held across accesses
      step(idle(), strb(6'd40), "R2 strobe");
      step(idle(), mk(0, 1, 0, 0, 0, 0, 1, 6'd41, 16'h0007), "R2 adv in mode 0");
      step(mk(0, 0, 1, 0, 0, 0, 0, 6'd40, 16'h4040),
           mk(0, 1, 0, 0, 0, 1, 0, 6'd3, '0), "R2 latch held");
      step(idle(), mk(0, 1, 0, 0, 0, 1, 0, 6'd9, '0), "R2 latch held");
      step(idle(), mk(0, 0, 1, 1, 0, 1, 0, 6'd9, 16'h00EE), "R2 write via latch");
      step(mk(0, 1, 0, 0, 0, 0, 0, 6'd40, '0), idle(), "R2 readback");

      // R8: read sees old contents while the other port writes
      step(mk(0, 1, 0, 0, 0, 0, 0, 6'd20, '0),
           mk(0, 0, 1, 0, 0, 0, 0, 6'd20, 16'hBEEF), "R8 old data");
      step(mk(0, 1, 0, 0, 0, 0, 0, 6'd20, '0), idle(), "R8 new data");
      step(mk(0, 0, 1, 0, 0, 0, 0, 6'd21, 16'h1111),
           mk(0, 0, 1, 0, 0, 0, 0, 6'd22, 16'h2222), "R8 two writes");
      step(mk(0, 1, 0, 0, 0, 0, 0, 6'd21, '0),
           mk(0, 1, 0, 0, 0, 0, 0, 6'd22, '0), "R8 two reads");

      // R9: collisions
      step(mk(0, 0, 1, 0, 0, 0, 0, 6'd30, 16'hAAAA),
           mk(0, 0, 1, 0, 0, 0, 0, 6'd30, 16'h5555), "R9 full collision");
      step(idle(), mk(0, 1, 0, 0, 0, 0, 0, 6'd30, '0), "R9 readback");
      step(mk(0, 0, 1, 1, 0, 0, 0, 6'd31, 16'h1234),
           mk(0, 0, 1, 0, 0, 0, 0, 6'd31, 16'hABCD), "R9 partial collision");
      step(mk(0, 0, 1, 0, 1, 0, 0, 6'd32, 16'h7700),
           mk(0, 0, 1, 1, 0, 0, 0, 6'd32, 16'h0099), "R9 disjoint lanes");
      step(mk(0, 1, 0, 0, 0, 0, 0, 6'd31, '0),
           mk(0, 1, 0, 0, 0, 0, 0, 6'd32, '0), "R9 readback");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule